// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block decides the ordering of two unsigned words. Its building unit is a four-bit stage that examines bit pairs from the top down and raises one of three flags: A above B, A matching B, or A below B. Each stage also accepts a three-flag verdict from a less significant neighbour. It uses that verdict only when its own bits match, so identical stages can be chained from the low end of a word to the high end.

The top level chains as many stages as the configured operand width needs. It is set up by default for seven-bit operands, built from two stages. The low stage handles operand bits 3 down to 0. It is seeded with a "matching" verdict. Its flags feed the high stage, which handles bits 6 down to 4. The spare top bit of the high stage is held at zero on both operand sides. The whole path is combinational and has no clock or reset.

Top module: `cascade_mag_cmp`

## Requirements
- R1: `a_gt` is 1 exactly when `a_in` is greater than `b_in` as an unsigned 7-bit number.
- R2: `a_eq` is 1 exactly when `a_in` equals `b_in`.
- R3: `a_lt` is 1 exactly when `a_in` is less than `b_in` as an unsigned 7-bit number.
- R4: For every operand pair, exactly one of `a_gt`, `a_eq` and `a_lt` is 1.
- R5: In a stage, the most significant unequal bit pair decides the result. If A has a 1 there, the gt flag is set. Otherwise the lt flag is set. Lower pairs are ignored.
- R6: When all local bit pairs of a stage are equal, the stage's {gt,eq,lt} outputs equal its cascade inputs bit for bit. This also holds for illegal cascade patterns (none set, or several set).
- R7: When any local bit pair of a stage differs, the cascade inputs have no effect on the stage outputs.
- R8: In the chain, the lowest stage receives gt=0, eq=1, lt=0 as its cascade verdict. Each stage's outputs drive the next higher stage's cascade inputs. Operand bits above the operand width are tied to 0 on both sides.
- R9: When a stage's cascade inputs have exactly one flag set, exactly one of its outputs is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 7 | Operand A, unsigned |
| b_in | input | 7 | Operand B, unsigned |
| a_gt | output | 1 | A greater than B |
| a_eq | output | 1 | A equal to B |
| a_lt | output | 1 | A less than B |

## Verification
Two functions can meet in one evaluation. A local bit-pair decision in the high stage can happen alongside a cascade verdict arriving from the low stage. The high stage must let its own unequal bits override that verdict, and it must defer to the verdict only when bits 6 to 4 match. A full sweep over all operand pairs creates every such meeting: high bits equal with low bits differing, both differing, and both equal. Each result is judged against the unsigned ordering computed arithmetically. A lone stage is also swept over every local pair combined with all eight cascade patterns. This shows that illegal verdicts pass through unchanged and that verdicts are ignored whenever the local bits differ.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } rel_t;

  localparam rel_t REL_SEED = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
endpackage

// File: rtl/cmp_bit_cell.sv
module cmp_bit_cell (
  input  logic a_bit,
  input  logic b_bit,
  output logic bit_gt,
  output logic bit_lt,
  output logic bit_eq
);
  always_comb begin
    bit_gt = a_bit & ~b_bit;
    bit_lt = ~a_bit & b_bit;
    bit_eq = ~(a_bit ^ b_bit);
  end
endmodule

// File: rtl/cmp_stage.sv
module cmp_stage
  import cmp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_word,
  input  logic [W-1:0] b_word,
  input  rel_t         cas_in,
  output rel_t         rel_out
);
  logic [W-1:0] pair_gt, pair_lt, pair_eq;
  logic [W:0]   eq_above;   // eq_above[i]: all pairs at index >= i match
  logic         win_gt, win_lt, all_eq;

  assign eq_above[W] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_pair
    cmp_bit_cell u_cell (
      .a_bit  (a_word[i]),
      .b_bit  (b_word[i]),
      .bit_gt (pair_gt[i]),
      .bit_lt (pair_lt[i]),
      .bit_eq (pair_eq[i])
    );
    assign eq_above[i] = eq_above[i+1] & pair_eq[i];
  end

  always_comb begin
    win_gt = |(pair_gt & eq_above[W:1]);
    win_lt = |(pair_lt & eq_above[W:1]);
    all_eq = eq_above[0];
    rel_out.gt = win_gt | (all_eq & cas_in.gt);
    rel_out.lt = win_lt | (all_eq & cas_in.lt);
    rel_out.eq = all_eq & cas_in.eq;
  end

  always_comb begin
    // R5: ordering of the local words fixes the verdict
    a_r5_msb_decides: assert (!(a_word > b_word) || (rel_out == '{gt:1'b1, eq:1'b0, lt:1'b0}))
      else $error("a_r5_msb_decides");
    // R6: matching words forward the neighbour verdict untouched
    a_r6_passthru: assert (a_word != b_word || rel_out == cas_in)
      else $error("a_r6_passthru");
    // R7: differing words never report equality
    a_r7_cas_ignored: assert (a_word == b_word || !rel_out.eq)
      else $error("a_r7_cas_ignored");
    // R9: a legal verdict in gives a legal verdict out
    a_r9_onehot: assert (!$onehot(cas_in) || $onehot(rel_out))
      else $error("a_r9_onehot");
  end
endmodule

// File: rtl/cascade_mag_cmp.sv
module cascade_mag_cmp
  import cmp_pkg::*;
#(
  parameter int WIDTH   = 7,
  parameter int STAGE_W = 4
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic             a_gt,
  output logic             a_eq,
  output logic             a_lt
);
  localparam int NSTAGE = (WIDTH + STAGE_W - 1) / STAGE_W;
  localparam int PAD_W  = NSTAGE * STAGE_W;

  logic [PAD_W-1:0] a_pad, b_pad;
  rel_t             link [NSTAGE+1];

  // R8: spare upper bits held at zero on both sides, chain seeded as equal
  assign a_pad   = PAD_W'(a_in);
  assign b_pad   = PAD_W'(b_in);
  assign link[0] = REL_SEED;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    cmp_stage #(.W(STAGE_W)) u_stage (
      .a_word  (a_pad[s*STAGE_W +: STAGE_W]),
      .b_word  (b_pad[s*STAGE_W +: STAGE_W]),
      .cas_in  (link[s]),
      .rel_out (link[s+1])
    );
  end

  assign a_gt = link[NSTAGE].gt;
  assign a_eq = link[NSTAGE].eq;
  assign a_lt = link[NSTAGE].lt;

  always_comb begin
    a_r4_one_flag: assert ($onehot({a_gt, a_eq, a_lt}))
      else $error("a_r4_one_flag");
    a_r1_greater: assert (a_gt == (a_in > b_in))
      else $error("a_r1_greater");
    a_r3_less: assert (a_lt == (a_in < b_in))
      else $error("a_r3_less");
  end
endmodule

// File: tb/cascade_mag_cmp_bench.sv
module cascade_mag_cmp_bench;
  import cmp_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;   // 250 MHz

  logic [6:0] a_in, b_in;
  logic       a_gt, a_eq, a_lt;
  logic [3:0] sa, sb;
  rel_t       scas, sout;

  int  n_vec  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  cascade_mag_cmp u_cascade_mag_cmp (
    .a_in (a_in), .b_in (b_in),
    .a_gt (a_gt), .a_eq (a_eq), .a_lt (a_lt)
  );

  cmp_stage #(.W(4)) u_stage (
    .a_word (sa), .b_word (sb), .cas_in (scas), .rel_out (sout)
  );

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: a=%0d b=%0d got %b expected %b", req, a_in, b_in, got, exp);
    end
  endtask

  task automatic check_stage(input string req, input logic [2:0] got, input logic [2:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: a=%0d b=%0d cas=%b got %b expected %b", req, sa, sb, scas, got, exp);
    end
  endtask

  initial begin
    a_in = '0; b_in = '0; sa = '0; sb = '0; scas = REL_SEED;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R2 reset-state zero operands", {a_gt, a_eq, a_lt}, 3'b010);

    // Full sweep of the 7-bit chain (R1 R2 R3 R4 R8)
    for (int a = 0; a < 128; a++) begin
      for (int b = 0; b < 128; b++) begin
        @(negedge clk);
        a_in = 7'(a); b_in = 7'(b);
        #1;
        if (a > b)       check("R1 greater", {a_gt, a_eq, a_lt}, 3'b100);
        else if (a < b)  check("R3 less",    {a_gt, a_eq, a_lt}, 3'b001);
        else             check("R2 equal",   {a_gt, a_eq, a_lt}, 3'b010);
        if ((a >> 4) == (b >> 4) && (a & 15) != (b & 15))
          check("R8 low stage decides via cascade", {a_gt, a_lt}, {a > b, a < b});
        check("R4 single flag", 3'($countones({a_gt, a_eq, a_lt})), 3'd1);
      end
    end

    // Lone-stage sweep with every cascade pattern (R5 R6 R7 R9)
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int c = 0; c < 8; c++) begin
          @(negedge clk);
          sa = 4'(a); sb = 4'(b); scas = rel_t'(3'(c));
          #1;
          if (a > b)      check_stage("R5 local greater, R7 cascade ignored", sout, 3'b100);
          else if (a < b) check_stage("R5 local less, R7 cascade ignored", sout, 3'b001);
          else            check_stage("R6 pass-through", sout, 3'(c));
          if (c == 1 || c == 2 || c == 4)
            check_stage("R9 one-hot out", 3'($countones(sout)), 3'd1);
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule